// File: doc/BRIEF.md
# PLL Relock Switching Sequencer

This block changes the multiplier, pre-divider and post-scaler settings of a core PLL while the processor keeps running from a second clock source. On a start strobe it captures a 32-bit setting word. It then moves the core clock mux to the alternate (backup) PLL and waits until the mux status shows that the switch has finished. Next it loads the lock-time value, which is derived from the new pre-divider, and writes the new fields into the PLL configuration word. Every other bit of that word keeps its current value.

After the PLL reports lock, the sequencer moves the mux back to the primary PLL. When the mux status confirms the return, it ends the operation with a one-cycle done pulse. The configuration write is a read-modify-write: the block reads the current word on `cfg_i` and returns the merged word on `cfg_o`, together with a one-cycle write enable.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset, `mux_sel_o`, `busy_o`, `done_o` and `cfg_we_o` are 0, and `lock_time_o` is 0.
- R2: A `start_i` high in a clock cycle while idle makes `busy_o` high and `mux_sel_o` 1 (alternate PLL) from the next cycle on. While `busy_o` is low, `mux_sel_o` is 0 (primary PLL).
- R3: The block does no configuration write until it has sampled `mux_stat_i` equal to 2 (alternate selected) while `mux_sel_o` is 1.
- R4: While `cfg_we_o` is high, `lock_time_o` equals P × 250. P is bits [13:8] of the captured setting word.
- R5: The configuration write is a single-cycle `cfg_we_o` pulse. During that cycle `cfg_o` equals `cfg_i` with bits [25:16] replaced by M, bits [13:8] by P and bits [2:0] by S, all taken from the captured word. The other bits come from `cfg_i` unchanged.
- R6: `mux_sel_o` returns to 0 only in the cycle after `locked_i` was sampled high, and only after the configuration write.
- R7: `done_o` rises only in the cycle after `mux_stat_i` was sampled equal to 1 (primary selected) with `mux_sel_o` at 0. It lasts exactly one cycle, and `busy_o` falls in the same cycle.
- R8: The setting word is captured on the accepted start. `start_i` and `pms_i` are ignored while `busy_o` is high, so each operation makes exactly one configuration write, and that write uses the captured word.
- R9: Status codes other than the awaited one (0 and 3 to 7 while parking, anything but 1 while returning) hold the sequencer in its wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| pms_i | input | 32 | Setting word: M at [25:16], P at [13:8], S at [2:0] |
| mux_sel_o | output | 1 | Core mux select: 0 primary PLL, 1 alternate PLL |
| mux_stat_i | input | 3 | Mux status: 1 primary active, 2 alternate active |
| lock_time_o | output | 14 | Lock-time count for the PLL |
| cfg_i | input | 32 | Current PLL configuration word |
| cfg_o | output | 32 | Merged configuration word to write |
| cfg_we_o | output | 1 | Configuration write enable, one cycle |
| locked_i | input | 1 | PLL locked flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is a stretch of intermediate or invalid mux status codes that lasts many cycles. The second is a lock flag that drops only after the write and comes back after a delay that depends on the pre-divider. The bench therefore runs a mux model with a chosen latency and a chosen junk status code during the transition. It also runs a PLL model that clears its lock on each write and counts down a scaled copy of the lock time. Extreme pre-dividers (0 and 63) and a long junk-status window are directed. During every run the bench also toggles `start_i` and `pms_i` at random, so that ignored input is exercised while the sequencer waits.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_PROG,
    ST_WAIT_LOCK,
    ST_RESUME
  } seq_state_e;
endpackage

// File: rtl/pms_field_merge.sv
module pms_field_merge #(
  parameter int WORD_W = 32,
  parameter int M_LSB  = 16,
  parameter int M_W    = 10,
  parameter int P_LSB  = 8,
  parameter int P_W    = 6,
  parameter int S_LSB  = 0,
  parameter int S_W    = 3
) (
  input  logic [WORD_W-1:0] cfg_i,
  input  logic [WORD_W-1:0] pms_i,
  output logic [WORD_W-1:0] merged_o,
  output logic [P_W-1:0]    p_o
);
  function automatic logic [WORD_W-1:0] fld(input int lsb, input int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FIELD_MASK =
    fld(M_LSB, M_W) | fld(P_LSB, P_W) | fld(S_LSB, S_W);

  assign merged_o = (cfg_i & ~FIELD_MASK) | (pms_i & FIELD_MASK);
  assign p_o      = pms_i[P_LSB +: P_W];
endmodule

// File: rtl/lock_time_calc.sv
module lock_time_calc #(
  parameter int P_W    = 6,
  parameter int MUL    = 250,
  parameter int LOCK_W = 14
) (
  input  logic [P_W-1:0]    p_i,
  output logic [LOCK_W-1:0] lock_o
);
  assign lock_o = LOCK_W'(p_i) * LOCK_W'(MUL);
endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import pll_relock_pkg::*;
#(
  parameter int          STAT_W   = 3,
  parameter int unsigned STAT_PRI = 1,
  parameter int unsigned STAT_ALT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STAT_W-1:0] mux_stat_i,
  input  logic              locked_i,
  output logic              capture_o,
  output logic              lock_load_o,
  output logic              cfg_we_o,
  output logic              mux_sel_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e state_q;

  wire stat_alt = (mux_stat_i == STAT_W'(STAT_ALT));
  wire stat_pri = (mux_stat_i == STAT_W'(STAT_PRI));

  assign capture_o   = (state_q == ST_IDLE) && start_i;
  assign lock_load_o = (state_q == ST_PARK) && stat_alt;
  // write is combinational so the PLL sees it in the PROG cycle and drops lock before WAIT_LOCK samples it
  assign cfg_we_o    = (state_q == ST_PROG);
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mux_sel_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_PARK;
          mux_sel_o <= 1'b1;
        end
        ST_PARK: if (stat_alt) state_q <= ST_PROG;
        ST_PROG: state_q <= ST_WAIT_LOCK;
        ST_WAIT_LOCK: if (locked_i) begin
          state_q   <= ST_RESUME;
          mux_sel_o <= 1'b0;
        end
        ST_RESUME: if (stat_pri) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq #(
  parameter int          WORD_W   = 32,
  parameter int          M_LSB    = 16,
  parameter int          M_W      = 10,
  parameter int          P_LSB    = 8,
  parameter int          P_W      = 6,
  parameter int          S_LSB    = 0,
  parameter int          S_W      = 3,
  parameter int          LOCK_MUL = 250,
  parameter int          STAT_W   = 3,
  parameter int unsigned STAT_PRI = 1,
  parameter int unsigned STAT_ALT = 2,
  localparam int         LOCK_W   = $clog2(((1 << P_W) - 1) * LOCK_MUL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] pms_i,
  output logic              mux_sel_o,
  input  logic [STAT_W-1:0] mux_stat_i,
  output logic [LOCK_W-1:0] lock_time_o,
  input  logic [WORD_W-1:0] cfg_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              cfg_we_o,
  input  logic              locked_i,
  output logic              busy_o,
  output logic              done_o
);
  logic              capture, lock_load;
  logic [WORD_W-1:0] pms_q;
  logic [P_W-1:0]    p_field;
  logic [LOCK_W-1:0] lock_calc;

  relock_fsm #(
    .STAT_W(STAT_W), .STAT_PRI(STAT_PRI), .STAT_ALT(STAT_ALT)
  ) i_fsm (
    .clk_i, .rst_ni, .start_i, .mux_stat_i, .locked_i,
    .capture_o(capture), .lock_load_o(lock_load), .cfg_we_o,
    .mux_sel_o, .busy_o, .done_o
  );

  pms_field_merge #(
    .WORD_W(WORD_W), .M_LSB(M_LSB), .M_W(M_W), .P_LSB(P_LSB), .P_W(P_W),
    .S_LSB(S_LSB), .S_W(S_W)
  ) i_merge (
    .cfg_i, .pms_i(pms_q), .merged_o(cfg_o), .p_o(p_field)
  );

  lock_time_calc #(
    .P_W(P_W), .MUL(LOCK_MUL), .LOCK_W(LOCK_W)
  ) i_lock (
    .p_i(p_field), .lock_o(lock_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pms_q       <= '0;
      lock_time_o <= '0;
    end else begin
      if (capture)   pms_q       <= pms_i;
      if (lock_load) lock_time_o <= lock_calc;
    end
  end
endmodule

// File: rtl/pll_relock_chk.sv
module pll_relock_chk #(
  parameter int WORD_W   = 32,
  parameter int P_LSB    = 8,
  parameter int P_W      = 6,
  parameter int LOCK_MUL = 250,
  parameter int LOCK_W   = 14,
  parameter int STAT_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mux_sel_o,
  input logic [STAT_W-1:0] mux_stat_i,
  input logic [LOCK_W-1:0] lock_time_o,
  input logic [WORD_W-1:0] cfg_o,
  input logic              cfg_we_o,
  input logic              locked_i,
  input logic              busy_o,
  input logic              done_o
);
  // R2
  idle_primary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mux_sel_o);
  // R3
  park_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> mux_sel_o && $past(mux_stat_i) == STAT_W'(2));
  // R4
  lock_time_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> lock_time_o == LOCK_W'(cfg_o[P_LSB +: P_W]) * LOCK_W'(LOCK_MUL));
  // R5
  write_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |=> !cfg_we_o);
  // R6
  resume_after_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mux_sel_o) |-> $past(locked_i));
  // R7
  done_after_primary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mux_stat_i) == STAT_W'(1) && !$past(mux_sel_o));
  // R7
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind pll_relock_seq pll_relock_chk #(
  .WORD_W(WORD_W), .P_LSB(P_LSB), .P_W(P_W), .LOCK_MUL(LOCK_MUL),
  .LOCK_W(LOCK_W), .STAT_W(STAT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mux_sel_o(mux_sel_o), .mux_stat_i(mux_stat_i),
  .lock_time_o(lock_time_o), .cfg_o(cfg_o), .cfg_we_o(cfg_we_o),
  .locked_i(locked_i), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_pll_relock_seq.sv
module test_pll_relock_seq;
  localparam logic [31:0] FMASK = 32'h03FF_3F07;
  localparam logic [31:0] CFG_INIT = 32'hF800_C0F8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pms = '0;
  logic [2:0]  mux_stat;
  logic [31:0] pll_cfg;
  logic        locked;
  logic        mux_sel, cfg_we, busy, done;
  logic [13:0] lock_time;
  logic [31:0] cfg_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mux_lat = 2;
  logic [2:0] mux_bogus = 3'd0;

  always #2ns clk = ~clk;

  pll_relock_seq i_pll_relock_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pms_i(pms),
    .mux_sel_o(mux_sel), .mux_stat_i(mux_stat), .lock_time_o(lock_time),
    .cfg_i(pll_cfg), .cfg_o(cfg_out), .cfg_we_o(cfg_we), .locked_i(locked),
    .busy_o(busy), .done_o(done)
  );

  // mux model: junk status for mux_lat cycles after a select change
  logic mux_tgt;
  int   mux_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_stat <= 3'd1; mux_tgt <= 1'b0; mux_cnt <= 0;
    end else if (mux_sel != mux_tgt) begin
      mux_tgt <= mux_sel; mux_cnt <= mux_lat; mux_stat <= mux_bogus;
    end else if (mux_cnt > 0) begin
      mux_cnt <= mux_cnt - 1; mux_stat <= mux_bogus;
    end else begin
      mux_stat <= mux_tgt ? 3'd2 : 3'd1;
    end
  end

  // PLL model: lock drops on write, returns after lock_time/16 cycles
  int lk_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1; lk_cnt <= 0; pll_cfg <= CFG_INIT;
    end else if (cfg_we) begin
      pll_cfg <= cfg_out; locked <= 1'b0; lk_cnt <= int'(lock_time >> 4);
    end else if (!locked) begin
      if (lk_cnt == 0) locked <= 1'b1;
      else lk_cnt <= lk_cnt - 1;
    end
  end

  function automatic logic [31:0] exp_merge(input logic [31:0] c, input logic [31:0] p);
    return (c & ~FMASK) | (p & FMASK);
  endfunction

  function automatic logic [13:0] exp_lock(input logic [31:0] p);
    return 14'(p[13:8]) * 14'd250;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_seq(input logic [31:0] p);
    logic [31:0] expc;
    bit seen2, fin, prev_lock, prev_sel;
    logic [2:0] prev_stat;
    int nwe;
    expc = exp_merge(pll_cfg, p);
    seen2 = 0; fin = 0; nwe = 0;
    start = 1'b1; pms = p;
    @(negedge clk);
    start = 1'b0;
    chk(busy && mux_sel, "R2 start moves to alternate", {30'd0, busy, mux_sel}, 32'd3);
    prev_lock = locked; prev_stat = mux_stat; prev_sel = mux_sel;
    for (int i = 0; i < 20000 && !fin; i++) begin
      @(negedge clk);
      if (cfg_we) begin
        nwe++;
        chk(cfg_out == expc, "R5 merged config", cfg_out, expc);
        chk(lock_time == exp_lock(p), "R4 lock time", 32'(lock_time), 32'(exp_lock(p)));
        chk(seen2, "R3 R9 write only after alternate status", 32'(seen2), 32'd1);
      end
      if (prev_sel && !mux_sel)
        chk(prev_lock && nwe == 1, "R6 resume after lock", 32'(prev_lock), 32'd1);
      if (done) begin
        chk(prev_stat == 3'd1 && !busy && !prev_sel, "R7 done after primary status",
            {29'd0, prev_stat}, 32'd1);
        fin = 1;
      end
      if (mux_sel && mux_stat == 3'd2) seen2 = 1;
      prev_lock = locked; prev_stat = mux_stat; prev_sel = mux_sel;
      // R8 disturbance while busy
      if (busy) begin
        pms = $urandom; start = ($urandom % 4) == 0;
      end else begin
        start = 1'b0;
      end
    end
    chk(fin, "R7 completion reached", 32'(fin), 32'd1);
    chk(nwe == 1, "R8 R5 one write per operation", nwe, 32'd1);
    chk(pll_cfg == expc, "R8 captured word written", pll_cfg, expc);
    @(negedge clk);
    chk(!done && !busy && !mux_sel && !cfg_we, "R7 R8 single pulse, no restart",
        {28'd0, done, busy, mux_sel, cfg_we}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!mux_sel && !busy && !done && !cfg_we && lock_time == 14'd0, "R1 reset state",
        {13'd0, lock_time, mux_sel, busy, done, cfg_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mux_sel && !busy, "R2 idle on primary", {30'd0, mux_sel, busy}, 32'd0);
    // directed examples
    run_seq({6'h3F, 10'd250, 2'b11, 6'd4, 5'h1F, 3'd0});
    run_seq({6'h00, 10'd175, 2'b00, 6'd3, 5'h00, 3'd1});
    run_seq({6'h15, 10'd100, 2'b01, 6'd3, 5'h0A, 3'd2});
    // pre-divider extremes
    run_seq({6'h00, 10'd512, 2'b00, 6'd0, 5'h00, 3'd7});
    run_seq({6'h00, 10'd1023, 2'b00, 6'd63, 5'h00, 3'd5});
    // long junk status window (R9)
    mux_lat = 25; mux_bogus = 3'd3;
    run_seq({6'h00, 10'd300, 2'b00, 6'd5, 5'h00, 3'd1});
    mux_lat = 10; mux_bogus = 3'd7;
    run_seq({6'h00, 10'd200, 2'b00, 6'd2, 5'h00, 3'd0});
    // random
    for (int k = 0; k < 25; k++) begin
      logic [2:0] b;
      mux_lat = $urandom % 6;
      b = 3'($urandom % 8);
      if (b == 3'd1 || b == 3'd2) b = 3'd0;
      mux_bogus = b;
      repeat ($urandom % 3) @(negedge clk);
      run_seq($urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule